// File: doc/BRIEF.md
# Bridge Address Discovery Responder

This block sits beside a packet host bridge and answers discovery queries from the host. A host tool uses these queries to learn where the standard cores of a system-on-chip sit, without a separate address file. Requests arrive as already de-encapsulated byte packets on a valid/ready/last stream. They carry their own magic value, so they can share a port with the bridge's normal traffic. Replies leave on a second byte stream of the same kind.

The published cores are held in a record table that is set by a parameter. A host can walk the table in pages: it sends a first detect request, then continue requests, each capped by a maximum count it chooses. It can also ask for every instance of one well-known identifier. Each reply carries a header with the number of records that follow and a flag saying whether more are left. Packets that are malformed, of an unsupported version or of an unsupported type are discarded without a reply.

Top module: `disc_responder`

## Requirements
- R1: Every reply begins with the bytes 0x4E then 0x9F. A request whose first two bytes are not 0x4E, 0x9F gets no reply.
- R2: Header byte 2 holds the version in bits 7:4 and the type in bits 3:0. Byte 3 is the actual record count and byte 4 the maximum count. Byte 5 holds the more flag in bit 7 and the feature flags in bits 6:0. A reply echoes the request's maximum count in byte 4 and sends feature flags 0x03 (bit 0: continue supported, bit 1: identifier lookup supported). Request bytes 3 and 5 are ignored.
- R3: Only version 1 is accepted, and only the request types 0 (detect), 2 (continue) and 3 (identifier lookup). Any other version or type, including the reply types 1 and 4, gets no reply.
- R4: A detect request gets a reply of type 1. The reply carries the records from index 0 in table order, and their number is the smaller of the requested maximum and the table depth (5 records by default).
- R5: The more flag of a detect or continue reply is 1 exactly when published records remain after the last one sent.
- R6: A continue request gets a type 1 reply that resumes at the record after the last one returned by the previous detect or continue, and the count and more rules of R4 and R5 apply. A detect that returned no records leaves the next continue starting at index 0. A continue gets no reply after reset or once a walk has ended with the more flag clear.
- R7: An identifier lookup carries the wanted identifier in request bytes 6 (high) and 7 (low). It gets a type 4 reply with the matching records in table order. The count is the smaller of the maximum and the number of matches, and the more flag is 1 exactly when the matches exceed the maximum. A lookup does not change the walk position used by continue.
- R8: Each record is 12 bytes, most significant byte first: a 16-bit identifier, a 32-bit base address, a 16-bit version and 32 flag bits.
- R9: A reply with no records is still sent. It is the 6 header bytes alone, with last on byte 5. A lookup that matches nothing sends such a reply with the more flag clear.
- R10: A request shorter than 6 bytes, or a lookup shorter than 8 bytes, gets no reply. Bytes beyond those needed are ignored.
- R11: in_ready_o is low from the cycle after the last byte of a request is accepted until its reply ends. out_data_o and out_last_o hold while out_valid_o is high and out_ready_i is low. out_last_o marks the final reply byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request byte valid |
| in_data_i | input | 8 | Request byte |
| in_last_i | input | 1 | Final byte of request |
| in_ready_o | output | 1 | Request byte accepted when high with valid |
| out_valid_o | output | 1 | Reply byte valid |
| out_data_o | output | 8 | Reply byte |
| out_last_o | output | 1 | Final byte of reply |
| out_ready_i | input | 1 | Reply byte taken when high with valid |

## Verification
A wrong walk position shows on the first continue after it goes wrong. The reply's first record is then the wrong one and its count or more flag disagree, within the first eighteen bytes of that reply. A stuck pending flag shows either as a reply to a continue that should be discarded, which is caught as an unexpected byte, or as a missing reply. A bad selection or byte order in the record path shows as a miscompare on the exact byte where it goes wrong. Stalls on the output check that the sequencer state holds steady.

// File: rtl/disc_pkg.sv
package disc_pkg;
  localparam logic [15:0] MAGIC     = 16'h4E9F;
  localparam int          HDR_BYTES = 6;
  localparam int          REC_BYTES = 12;
  localparam int          REC_W     = 8 * REC_BYTES;
  localparam int          CNT_W     = 8;

  typedef enum logic [3:0] {
    T_DET_REQ  = 4'd0,
    T_DET_ACK  = 4'd1,
    T_DET_CONT = 4'd2,
    T_ADDR_REQ = 4'd3,
    T_ADDR_RSP = 4'd4
  } msg_t;

  typedef struct packed {
    logic [15:0] id;
    logic [31:0] base;
    logic [15:0] ver;
    logic [31:0] flags;
  } rec_t;
endpackage

// File: rtl/disc_req_parser.sv
module disc_req_parser
  import disc_pkg::*;
#(
  parameter logic [3:0] VERSION = 4'd1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        in_valid_i,
  input  logic [7:0]  in_data_i,
  input  logic        in_last_i,
  output logic        in_ready_o,
  output logic        ok_o,
  output logic [3:0]  type_o,
  output logic [7:0]  max_o,
  output logic [15:0] id_o
);
  logic        beat;
  logic [3:0]  pos_q, len_q;
  logic [15:0] magic_q;
  logic [3:0]  ver_q;

  assign in_ready_o = en_i;
  assign beat       = in_valid_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      len_q   <= '0;
      magic_q <= '0;
      ver_q   <= '0;
      type_o  <= '0;
      max_o   <= '0;
      id_o    <= '0;
    end else if (beat) begin
      case (pos_q)
        4'd0: magic_q[15:8]     <= in_data_i;
        4'd1: magic_q[7:0]      <= in_data_i;
        4'd2: {ver_q, type_o}   <= in_data_i;
        4'd4: max_o             <= in_data_i;
        4'd6: id_o[15:8]        <= in_data_i;
        4'd7: id_o[7:0]         <= in_data_i;
        default: ;
      endcase
      len_q <= pos_q + 4'd1;
      if (in_last_i)         pos_q <= '0;
      else if (pos_q != 4'd8) pos_q <= pos_q + 4'd1;
    end
  end

  // evaluated one cycle after the last byte, all fields registered
  always_comb begin
    ok_o = (magic_q == MAGIC) && (ver_q == VERSION);
    case (type_o)
      T_DET_REQ, T_DET_CONT: ok_o = ok_o && (len_q >= 4'd6);
      T_ADDR_REQ:            ok_o = ok_o && (len_q >= 4'd8);
      default:               ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/disc_rec_select.sv
module disc_rec_select
  import disc_pkg::*;
#(
  parameter int                    NREC  = 5,
  parameter int                    IDX_W = 3,
  parameter logic [NREC*REC_W-1:0] TABLE = '0
) (
  input  logic             addr_mode_i,
  input  logic [15:0]      id_i,
  input  logic [IDX_W-1:0] from_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [IDX_W-1:0] next_o,
  output logic [IDX_W-1:0] match_cnt_o,
  output rec_t             rec_o
);
  rec_t            recs [NREC];
  logic [NREC-1:0] hit;

  for (genvar g = 0; g < NREC; g++) begin : g_rec
    assign recs[g] = TABLE[g*REC_W +: REC_W];
    assign hit[g]  = (recs[g].id == id_i);
  end

  // first selected index at or after from_i; NREC when none
  always_comb begin
    next_o = IDX_W'(NREC);
    for (int i = NREC - 1; i >= 0; i--) begin
      if (IDX_W'(i) >= from_i && (!addr_mode_i || hit[i])) next_o = IDX_W'(i);
    end
  end

  always_comb begin
    match_cnt_o = '0;
    for (int i = 0; i < NREC; i++) match_cnt_o = match_cnt_o + IDX_W'(hit[i]);
  end

  assign rec_o = (rd_idx_i < IDX_W'(NREC)) ? recs[rd_idx_i] : '0;
endmodule

// File: rtl/disc_responder.sv
module disc_responder
  import disc_pkg::*;
#(
  parameter int                    NREC    = 5,
  parameter logic [3:0]            VERSION = 4'd1,
  parameter logic [6:0]            FEAT    = 7'h03,
  parameter logic [NREC*REC_W-1:0] TABLE   = {
    {16'h0010, 32'h0000_4800, 16'h0003, 32'h0000_0003},
    {16'h0030, 32'h8000_0000, 16'h0200, 32'hDEAD_BEEF},
    {16'h0010, 32'h0000_3000, 16'h0001, 32'h0000_0002},
    {16'h0020, 32'h0000_2000, 16'h0102, 32'h0000_0000},
    {16'h0010, 32'h0000_1000, 16'h0001, 32'hA000_0001}
  }
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_valid_i,
  input  logic [7:0] in_data_i,
  input  logic       in_last_i,
  output logic       in_ready_o,
  output logic       out_valid_o,
  output logic [7:0] out_data_o,
  output logic       out_last_o,
  input  logic       out_ready_i
);
  localparam int IDX_W = $clog2(NREC + 1);

  typedef enum logic [1:0] {S_RX, S_EVAL, S_HDR, S_REC} st_t;

  st_t              st_q;
  logic             p_ok;
  logic [3:0]       p_type;
  logic [7:0]       p_max;
  logic [15:0]      p_id;
  logic             is_addr, is_cont, take, more_n;
  logic [IDX_W-1:0] start, q_from, sel_next, match_cnt, ptr_q, pend_q;
  logic             pend_vld_q, more_q;
  logic [CNT_W-1:0] avail, cnt_n, cnt_q, left_q, max_q;
  msg_t             rsp_q;
  logic [3:0]       bidx_q;
  rec_t             rec;

  disc_req_parser #(.VERSION(VERSION)) i_parser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (st_q == S_RX),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .in_last_i  (in_last_i),
    .in_ready_o (in_ready_o),
    .ok_o       (p_ok),
    .type_o     (p_type),
    .max_o      (p_max),
    .id_o       (p_id)
  );

  assign is_addr = (p_type == T_ADDR_REQ);
  assign is_cont = (p_type == T_DET_CONT);
  assign take    = p_ok && (!is_cont || pend_vld_q);
  assign start   = is_cont ? pend_q : '0;
  assign q_from  = (st_q == S_EVAL) ? start : IDX_W'(ptr_q + 1'b1);
  assign avail   = is_addr ? CNT_W'(match_cnt) : CNT_W'(NREC) - CNT_W'(start);
  assign cnt_n   = (p_max < avail) ? p_max : avail;
  assign more_n  = (avail > p_max);

  disc_rec_select #(.NREC(NREC), .IDX_W(IDX_W), .TABLE(TABLE)) i_select (
    .addr_mode_i (is_addr),
    .id_i        (p_id),
    .from_i      (q_from),
    .rd_idx_i    (ptr_q),
    .next_o      (sel_next),
    .match_cnt_o (match_cnt),
    .rec_o       (rec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_RX;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      more_q     <= 1'b0;
      cnt_q      <= '0;
      left_q     <= '0;
      max_q      <= '0;
      rsp_q      <= T_DET_ACK;
      ptr_q      <= '0;
      bidx_q     <= '0;
    end else begin
      case (st_q)
        S_RX: if (in_valid_i && in_last_i) st_q <= S_EVAL;
        S_EVAL: begin
          if (take) begin
            cnt_q  <= cnt_n;
            left_q <= cnt_n;
            more_q <= more_n;
            max_q  <= p_max;
            rsp_q  <= is_addr ? T_ADDR_RSP : T_DET_ACK;
            ptr_q  <= sel_next;
            bidx_q <= '0;
            st_q   <= S_HDR;
            if (!is_addr) begin
              pend_q     <= IDX_W'(CNT_W'(start) + cnt_n);
              pend_vld_q <= more_n;
            end
          end else begin
            st_q <= S_RX;
          end
        end
        S_HDR: if (out_ready_i) begin
          if (bidx_q == 4'(HDR_BYTES - 1)) begin
            bidx_q <= '0;
            st_q   <= (cnt_q == '0) ? S_RX : S_REC;
          end else begin
            bidx_q <= bidx_q + 4'd1;
          end
        end
        S_REC: if (out_ready_i) begin
          if (bidx_q == 4'(REC_BYTES - 1)) begin
            bidx_q <= '0;
            ptr_q  <= sel_next;
            left_q <= left_q - 1'b1;
            if (left_q == CNT_W'(1)) st_q <= S_RX;
          end else begin
            bidx_q <= bidx_q + 4'd1;
          end
        end
        default: st_q <= S_RX;
      endcase
    end
  end

  assign out_valid_o = (st_q == S_HDR) || (st_q == S_REC);

  always_comb begin
    out_data_o = '0;
    out_last_o = 1'b0;
    if (st_q == S_HDR) begin
      case (bidx_q)
        4'd0:    out_data_o = MAGIC[15:8];
        4'd1:    out_data_o = MAGIC[7:0];
        4'd2:    out_data_o = {VERSION, rsp_q};
        4'd3:    out_data_o = cnt_q;
        4'd4:    out_data_o = max_q;
        default: out_data_o = {more_q, FEAT};
      endcase
      out_last_o = (bidx_q == 4'(HDR_BYTES - 1)) && (cnt_q == '0);
    end else if (st_q == S_REC) begin
      out_data_o = rec[8*(REC_BYTES - 1 - int'(bidx_q)) +: 8];
      out_last_o = (bidx_q == 4'(REC_BYTES - 1)) && (left_q == CNT_W'(1));
    end
  end
endmodule

// File: rtl/disc_responder_chk.sv
module disc_responder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic       in_last_i,
  input logic       in_ready_o,
  input logic       out_valid_o,
  input logic [7:0] out_data_o,
  input logic       out_last_o,
  input logic       out_ready_i
);
  logic [11:0] pos_q;
  logic [7:0]  cnt_q;
  logic        hs;

  assign hs = out_valid_o & out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      cnt_q <= '0;
    end else if (hs) begin
      if (pos_q == 12'd3) cnt_q <= out_data_o;
      if (out_last_o)              pos_q <= '0;
      else if (pos_q != 12'hFFF)   pos_q <= pos_q + 12'd1;
    end
  end

  AST_IN_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);  // R11
  AST_REQ_END_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && in_last_i |=> !in_ready_o);  // R11
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o));  // R11
  AST_MAGIC_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && pos_q == 12'd0 |-> out_data_o == 8'h4E);  // R1
  AST_MAGIC_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && pos_q == 12'd1 |-> out_data_o == 8'h9F);  // R1
  AST_RSP_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && pos_q == 12'd2 |-> out_data_o == 8'h11 || out_data_o == 8'h14);  // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && pos_q == 12'd4 |-> out_data_o >= cnt_q);  // R4
  AST_REPLY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && out_last_o |-> pos_q == 12'd5 + 12'd12 * {4'd0, cnt_q});  // R8
endmodule

bind disc_responder disc_responder_chk i_chk (.*);

// File: tb/test_disc_responder.sv
`timescale 1ns/1ps
module test_disc_responder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic       out_valid, out_last;
  logic [7:0] out_data;
  logic       out_ready = 1'b1;

  always #10 clk = ~clk;

  disc_responder i_disc_responder (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_last_o(out_last), .out_ready_i(out_ready)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 0, stall_en = 0;
  int stall_cnt = 0;
  string cur_tag = "R1";

  logic [8:0]  exp_q[$];
  string       tag_q[$];
  logic [7:0]  pkt_q[$];

  localparam int N = 5;
  logic [15:0] t_id   [N] = '{16'h0010, 16'h0020, 16'h0010, 16'h0030, 16'h0010};
  logic [31:0] t_base [N] = '{32'h0000_1000, 32'h0000_2000, 32'h0000_3000, 32'h8000_0000, 32'h0000_4800};
  logic [15:0] t_ver  [N] = '{16'h0001, 16'h0102, 16'h0001, 16'h0200, 16'h0003};
  logic [31:0] t_flg  [N] = '{32'hA000_0001, 32'h0000_0000, 32'h0000_0002, 32'hDEAD_BEEF, 32'h0000_0003};

  bit pend_v = 0;
  int pend = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  task automatic push(input logic [7:0] b, input bit last, input string tag);
    exp_q.push_back({last, b});
    tag_q.push_back(tag);
  endtask

  task automatic mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
    pkt_q.delete();
    pkt_q.push_back(b0); pkt_q.push_back(b1); pkt_q.push_back(b2);
    pkt_q.push_back(b3); pkt_q.push_back(b4); pkt_q.push_back(b5);
  endtask

  // reference model of the reply, from the requirements
  task automatic model(input string tag);
    int len, typ, maxc, cnt, start, avail;
    bit ok, more;
    int sel[$];
    logic [95:0] r;
    len = pkt_q.size();
    ok = (len >= 6);
    if (ok) ok = (pkt_q[0] == 8'h4E) && (pkt_q[1] == 8'h9F) && (pkt_q[2][7:4] == 4'd1);
    typ  = ok ? int'(pkt_q[2][3:0]) : 15;
    maxc = ok ? int'(pkt_q[4]) : 0;
    if (!(typ == 0 || typ == 2 || typ == 3)) ok = 0;
    if (typ == 3 && len < 8) ok = 0;
    if (typ == 2 && !pend_v) ok = 0;
    if (!ok) return;
    if (typ == 3) begin
      for (int i = 0; i < N; i++) if (t_id[i] == {pkt_q[6], pkt_q[7]}) sel.push_back(i);
      avail = sel.size();
      cnt = (maxc < avail) ? maxc : avail;
      more = avail > maxc;
    end else begin
      start = (typ == 2) ? pend : 0;
      avail = N - start;
      cnt = (maxc < avail) ? maxc : avail;
      more = avail > maxc;
      for (int i = 0; i < cnt; i++) sel.push_back(start + i);
      pend = start + cnt;
      pend_v = more;
    end
    push(8'h4E, 0, tag); push(8'h9F, 0, tag);
    push((typ == 3) ? 8'h14 : 8'h11, 0, tag);
    push(8'(cnt), 0, tag); push(8'(maxc), 0, tag);
    push({more, 7'h03}, cnt == 0, tag);
    for (int k = 0; k < cnt; k++) begin
      r = {t_id[sel[k]], t_base[sel[k]], t_ver[sel[k]], t_flg[sel[k]]};
      for (int b = 0; b < 12; b++) push(r[95 - 8*b -: 8], (k == cnt - 1) && (b == 11), tag);
    end
  endtask

  task automatic send(input string tag);
    cur_tag = tag;
    model(tag);
    for (int k = 0; k < pkt_q.size(); k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pkt_q[k]; in_last = (k == pkt_q.size() - 1);
      #2;
      while (!in_ready) begin @(negedge clk); #2; end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
    #2;
    check(exp_q.size() == 0 && !out_valid && in_ready, tag, "reply complete/idle",
          {out_valid, in_ready}, 1);
  endtask

  // monitor / scoreboard
  initial begin
    logic [8:0] e;
    string t;
    forever begin
      @(negedge clk);
      stall_cnt++;
      out_ready = stall_en ? ((stall_cnt % 4) != 3) : 1'b1;
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, cur_tag, "unexpected reply byte", {out_last, out_data}, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_last, out_data} == e && !in_ready, t, "reply byte {last,data}",
                {out_last, out_data}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(!out_valid && in_ready, "R11", "reset state {valid,ready}", {out_valid, in_ready}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    mk(8'h4E, 8'h9F, 8'h12, 8'h00, 8'h02, 8'h00); send("R6");   // continue after reset: dropped
    mk(8'h4E, 8'h9F, 8'h10, 8'h00, 8'h02, 8'h00); send("R4");   // detect, 2 of 5, more set (R5, R8)
    mk(8'h4E, 8'h9E, 8'h10, 8'h00, 8'h09, 8'h00); send("R1");   // bad magic: dropped
    mk(8'h9F, 8'h4E, 8'h12, 8'h00, 8'h09, 8'h00); send("R1");   // swapped magic: dropped
    stall_en = 1;
    mk(8'h4E, 8'h9F, 8'h12, 8'h07, 8'h02, 8'h7F); send("R6");   // continue: records 2,3
    mk(8'h4E, 8'h9F, 8'h22, 8'h00, 8'h05, 8'h00); send("R3");   // version 2: dropped
    mk(8'h4E, 8'h9F, 8'h12, 8'h00, 8'h05, 8'h00); send("R5");   // continue: record 4, more clear
    stall_en = 0;
    mk(8'h4E, 8'h9F, 8'h12, 8'h00, 8'h05, 8'h00); send("R6");   // walk ended: dropped
    mk(8'h4E, 8'h9F, 8'h11, 8'h00, 8'h05, 8'h00); send("R3");   // type 1: dropped
    mk(8'h4E, 8'h9F, 8'h14, 8'h00, 8'h05, 8'h00); send("R3");   // type 4: dropped
    mk(8'h4E, 8'h9F, 8'h17, 8'h00, 8'h05, 8'h00); send("R3");   // type 7: dropped
    pkt_q.delete(); pkt_q.push_back(8'h4E); pkt_q.push_back(8'h9F);
    pkt_q.push_back(8'h10); pkt_q.push_back(8'h00); send("R10"); // 4-byte detect: dropped
    mk(8'h4E, 8'h9F, 8'h13, 8'h00, 8'h04, 8'h00); pkt_q.push_back(8'h00); send("R10"); // 7-byte lookup
    mk(8'h4E, 8'h9F, 8'h10, 8'h00, 8'hFF, 8'h00);
    pkt_q.push_back(8'hAA); pkt_q.push_back(8'h55); pkt_q.push_back(8'h12); send("R10"); // trailing bytes
    mk(8'h4E, 8'h9F, 8'h10, 8'h00, 8'h01, 8'h00); send("R4");   // detect 1: pending at 1
    mk(8'h4E, 8'h9F, 8'h13, 8'h00, 8'h02, 8'h00);
    pkt_q.push_back(8'h00); pkt_q.push_back(8'h10); send("R7");  // lookup 0x0010 max 2: more set
    mk(8'h4E, 8'h9F, 8'h12, 8'h00, 8'h01, 8'h00); send("R7");   // continue after lookup: record 1
    mk(8'h4E, 8'h9F, 8'h13, 8'h00, 8'h09, 8'h00);
    pkt_q.push_back(8'h00); pkt_q.push_back(8'h10); send("R7");  // lookup all three matches
    mk(8'h4E, 8'h9F, 8'h13, 8'h00, 8'h04, 8'h00);
    pkt_q.push_back(8'h00); pkt_q.push_back(8'h99); send("R9");  // no match: header only
    mk(8'h4E, 8'h9F, 8'h10, 8'h00, 8'h00, 8'h00); send("R9");   // detect max 0: header, more set
    stall_en = 1;
    mk(8'h4E, 8'h9F, 8'h12, 8'h00, 8'h03, 8'h00); send("R6");   // continue from 0: records 0..2
    mk(8'h4E, 8'h9F, 8'h13, 8'h00, 8'h01, 8'h00);
    pkt_q.push_back(8'h00); pkt_q.push_back(8'h30); send("R8");  // lookup single record 3
    mk(8'h4E, 8'h9F, 8'h12, 8'h00, 8'h01, 8'h00); send("R2");   // continue: record 3, more set
    stall_en = 0;

    finished = 1;
    summary();
    $finish;
  end
endmodule